// File: doc/BRIEF.md
# Frame Drift Buffer Address Controller

This block generates the write and read addresses for a 2048-byte circular buffer. Bytes recovered from the disc are written into the buffer at the disc rate, and the output side reads them back at the crystal rate. The controller counts whole 32-byte frames on both sides. It keeps a signed frame offset, which is the distance between the two pointers minus the nominal 32-frame separation.

From that offset it selects the divisor for the write-side clock of the constant-linear-velocity servo. The divisor is 587 when writing runs ahead, 589 when writing lags, and 588 when the pointers sit exactly at the centre. If the drift reaches four frames in either direction, the controller snaps the write pointer back to the centre position. It then raises a mute request for 128 output frames, because error flags cannot mark the bytes that the jump corrupts.

The RAM array, the demodulator and the motor loop are outside the block. It takes one strobe per written byte and one strobe per read byte. It has no back-pressure: a strobe is always accepted in the cycle it is high. The address outputs give the location of the next byte on each side.

Top module: `jb_ctrl`

## Requirements
- R1: While `rst_n` is low, `divisor_o` is 588, `wr_addr_o` is 1024 (32 frames ahead), `rd_addr_o` is 0, `mute_o` is 1 and `motor_stop_o` is 1.
- R2: `motor_stop_o` falls on the first clock edge after `rst_n` goes high, and stays low.
- R3: Each `rd_stb_i` advances `rd_addr_o` by one on that clock edge, wrapping from 2047 to 0. Without a strobe, the address holds.
- R4: Each `wr_stb_i` advances `wr_addr_o` by one on that clock edge, wrapping modulo 2048, unless a recentre happens on that edge.
- R5: An offset of 0 frames gives `divisor_o` = 588.
- R6: An offset of -1, -2 or -3 frames (reading ahead of nominal) gives `divisor_o` = 589.
- R7: An offset of +1, +2 or +3 frames gives `divisor_o` = 587.
- R8: `divisor_o` changes only on an edge where a write frame or a read frame completes. A frame completes on the strobe whose address low five bits are 31.
- R9: If a completed write frame brings the offset to +4, then on that edge the offset returns to 0. `wr_addr_o` becomes the start of slot (read slot after that edge + 32) mod 64, and `divisor_o` becomes 588.
- R10: A completed read frame that brings the offset to -4 recentres in the same way as R9.
- R11: A recentre sets `mute_o` to 1 on that edge. `mute_o` then stays 1 until 128 read frames have completed after it.
- R12: A recentre while `mute_o` is already 1 restarts the 128-read-frame count.
- R13: After reset, `mute_o` stays 1 until 128 read frames have completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb_i | input | 1 | One byte written from the disc side this cycle |
| rd_stb_i | input | 1 | One byte read by the output side this cycle |
| wr_addr_o | output | 11 | Buffer address for the next written byte |
| rd_addr_o | output | 11 | Buffer address for the next read byte |
| divisor_o | output | 10 | Write-side clock divisor for the servo |
| mute_o | output | 1 | Output mute request (full attenuation) |
| motor_stop_o | output | 1 | Disc motor stop request |

## Verification
The bench builds the block with its default parameters: 11-bit addresses, 32-byte frames, a centre of 32 frames, a drift limit of 4 and a 128-frame mute. Every offset value from -4 to +4 can therefore be reached within a few frames. Long runs of paired write and read frames wrap both pointers several times and let the full mute window run out. With strobe patterns at unequal rates, a recentre can land while the read side is partway through a frame, and the bench also forces a second recentre inside an active mute window.

// File: rtl/jb_pkg.sv
package jb_pkg;

  // Direction of write-pointer drift relative to the centre position.
  typedef enum logic [1:0] {
    DRIFT_CENTRED = 2'd0,
    DRIFT_BEHIND  = 2'd1,
    DRIFT_AHEAD   = 2'd2
  } drift_e;

  function automatic drift_e classify_drift(input logic is_zero, input logic is_neg);
    if (is_zero)     return DRIFT_CENTRED;
    else if (is_neg) return DRIFT_BEHIND;
    else             return DRIFT_AHEAD;
  endfunction

endpackage

// File: rtl/jb_addr_gen.sv
module jb_addr_gen #(
  parameter int ADDR_W     = 11,
  parameter int FRAME_LOG2 = 5,
  parameter int START_SLOT = 0,
  parameter bit LOADABLE   = 1'b0,
  localparam int SLOT_W    = ADDR_W - FRAME_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] load_slot_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_done_o
);

  logic [ADDR_W-1:0] addr_q;
  localparam logic [ADDR_W-1:0] RESET_ADDR = {SLOT_W'(START_SLOT), FRAME_LOG2'(0)};

  // The byte index within a frame is the low part of the address, because a
  // load always lands on a slot boundary.
  assign frame_done_o = stb_i && (&addr_q[FRAME_LOG2-1:0]);
  assign addr_o       = addr_q;
  assign slot_o       = addr_q[ADDR_W-1:FRAME_LOG2];

  generate
    if (LOADABLE) begin : g_load
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr_q <= RESET_ADDR;
        else if (load_i) addr_q <= {load_slot_i, FRAME_LOG2'(0)};
        else if (stb_i)  addr_q <= addr_q + ADDR_W'(1);
      end
    end else begin : g_free
      logic unused_load;
      assign unused_load = load_i ^ (^load_slot_i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr_q <= RESET_ADDR;
        else if (stb_i) addr_q <= addr_q + ADDR_W'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/jb_offset_track.sv
module jb_offset_track
  import jb_pkg::*;
#(
  parameter int LIMIT = 4,
  localparam int OFS_W = $clog2(LIMIT + 1) + 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_fd_i,
  input  logic   rd_fd_i,
  output logic   recentre_o,
  output drift_e drift_o
);

  localparam logic signed [OFS_W-1:0] LIM_P = OFS_W'(LIMIT);
  localparam logic signed [OFS_W-1:0] LIM_N = -LIM_P;
  localparam logic signed [OFS_W-1:0] ONE   = OFS_W'(1);

  logic signed [OFS_W-1:0] ofs_q, ofs_nx, ofs_new;
  logic   boundary;
  drift_e drift_q;

  assign boundary = wr_fd_i || rd_fd_i;

  always_comb begin
    ofs_nx = ofs_q;
    if (wr_fd_i && !rd_fd_i)      ofs_nx = ofs_q + ONE;
    else if (rd_fd_i && !wr_fd_i) ofs_nx = ofs_q - ONE;
  end

  assign recentre_o = boundary && ((ofs_nx >= LIM_P) || (ofs_nx <= LIM_N));
  assign ofs_new    = recentre_o ? '0 : ofs_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q   <= '0;
      drift_q <= DRIFT_CENTRED;
    end else if (boundary) begin
      ofs_q   <= ofs_new;
      drift_q <= classify_drift(ofs_new == '0, ofs_new[OFS_W-1]);
    end
  end

  assign drift_o = drift_q;

endmodule

// File: rtl/jb_mute_timer.sv
module jb_mute_timer #(
  parameter int MUTE_FRAMES = 128,
  localparam int CNT_W = $clog2(MUTE_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recentre_i,
  input  logic rd_fd_i,
  output logic mute_o
);

  logic [CNT_W-1:0] cnt_q;

  // Reset loads a full window so output stays silent while the loop settles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= CNT_W'(MUTE_FRAMES);
    else if (recentre_i)             cnt_q <= CNT_W'(MUTE_FRAMES);
    else if (rd_fd_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign mute_o = (cnt_q != '0);

endmodule

// File: rtl/jb_ctrl.sv
module jb_ctrl
  import jb_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int FRAME_LOG2    = 5,
  parameter int CENTRE_FRAMES = 32,
  parameter int LIMIT         = 4,
  parameter int MUTE_FRAMES   = 128,
  parameter int DIV_W         = 10,
  parameter int DIV_NOM       = 588,
  parameter int DIV_STEP      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic              rd_stb_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DIV_W-1:0]  divisor_o,
  output logic              mute_o,
  output logic              motor_stop_o
);

  localparam int SLOT_W = ADDR_W - FRAME_LOG2;

  logic              wr_fd, rd_fd, recentre;
  logic [SLOT_W-1:0] wr_slot, rd_slot, rd_slot_nx, centre_slot;
  drift_e            drift;

  jb_addr_gen #(
    .ADDR_W(ADDR_W), .FRAME_LOG2(FRAME_LOG2), .START_SLOT(0), .LOADABLE(1'b0)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .stb_i(rd_stb_i), .load_i(1'b0),
    .load_slot_i('0), .addr_o(rd_addr_o), .slot_o(rd_slot),
    .frame_done_o(rd_fd)
  );

  // The centre target uses the read slot as it will be after this edge.
  assign rd_slot_nx  = rd_fd ? rd_slot + SLOT_W'(1) : rd_slot;
  assign centre_slot = rd_slot_nx + SLOT_W'(CENTRE_FRAMES);

  jb_addr_gen #(
    .ADDR_W(ADDR_W), .FRAME_LOG2(FRAME_LOG2), .START_SLOT(CENTRE_FRAMES),
    .LOADABLE(1'b1)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .stb_i(wr_stb_i), .load_i(recentre),
    .load_slot_i(centre_slot), .addr_o(wr_addr_o), .slot_o(wr_slot),
    .frame_done_o(wr_fd)
  );

  logic unused_slot;
  assign unused_slot = ^wr_slot;

  jb_offset_track #(.LIMIT(LIMIT)) u_ofs (
    .clk(clk), .rst_n(rst_n), .wr_fd_i(wr_fd), .rd_fd_i(rd_fd),
    .recentre_o(recentre), .drift_o(drift)
  );

  jb_mute_timer #(.MUTE_FRAMES(MUTE_FRAMES)) u_mute (
    .clk(clk), .rst_n(rst_n), .recentre_i(recentre), .rd_fd_i(rd_fd),
    .mute_o(mute_o)
  );

  always_comb begin
    unique case (drift)
      DRIFT_BEHIND: divisor_o = DIV_W'(DIV_NOM + DIV_STEP);
      DRIFT_AHEAD:  divisor_o = DIV_W'(DIV_NOM - DIV_STEP);
      default:      divisor_o = DIV_W'(DIV_NOM);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) motor_stop_o <= 1'b1;
    else        motor_stop_o <= 1'b0;
  end

endmodule

// File: rtl/jb_ctrl_chk.sv
module jb_ctrl_chk #(
  parameter int ADDR_W     = 11,
  parameter int FRAME_LOG2 = 5,
  parameter int DIV_W      = 10,
  parameter int DIV_NOM    = 588,
  parameter int DIV_STEP   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb_i,
  input logic              rd_stb_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [DIV_W-1:0]  divisor_o,
  input logic              mute_o,
  input logic              motor_stop_o,
  input logic              wr_fd,
  input logic              rd_fd,
  input logic              recentre
);

  p_motor_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !motor_stop_o);

  p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> rd_addr_o == $past(rd_addr_o) + ADDR_W'(1));

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rd_addr_o));

  p_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && !recentre) |=> wr_addr_o == $past(wr_addr_o) + ADDR_W'(1));

  p_div_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    divisor_o == DIV_W'(DIV_NOM) || divisor_o == DIV_W'(DIV_NOM + DIV_STEP) ||
    divisor_o == DIV_W'(DIV_NOM - DIV_STEP));

  p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fd || rd_fd) |=> $stable(divisor_o));

  p_recentre_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recentre |=> (wr_addr_o[FRAME_LOG2-1:0] == '0) && (divisor_o == DIV_W'(DIV_NOM)));

  p_recentre_mute_r11: assert property (@(posedge clk) disable iff (!rst_n)
    recentre |=> mute_o);

endmodule

bind jb_ctrl jb_ctrl_chk #(
  .ADDR_W(ADDR_W), .FRAME_LOG2(FRAME_LOG2), .DIV_W(DIV_W),
  .DIV_NOM(DIV_NOM), .DIV_STEP(DIV_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb_i), .rd_stb_i(rd_stb_i),
  .wr_addr_o(wr_addr_o), .rd_addr_o(rd_addr_o), .divisor_o(divisor_o),
  .mute_o(mute_o), .motor_stop_o(motor_stop_o), .wr_fd(wr_fd),
  .rd_fd(rd_fd), .recentre(recentre)
);

// File: tb/jb_ctrl_tb_top.sv
`timescale 1ns/1ps
module jb_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0, rd_stb = 1'b0;
  logic [10:0] wr_addr, rd_addr;
  logic [9:0]  divisor;
  logic        mute, motor_stop;

  always #10 clk = ~clk;  // 50 MHz

  jb_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .rd_stb_i(rd_stb),
    .wr_addr_o(wr_addr), .rd_addr_o(rd_addr), .divisor_o(divisor),
    .mute_o(mute), .motor_stop_o(motor_stop)
  );

  typedef struct {
    int div; int wa; int ra; int mu;
    int dreq; int wreq; int mreq;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  // Reference model state, built from the requirements.
  int          e_ofs = 0, e_mcnt = 128, e_msrc = 13, e_div = 588;
  logic [10:0] e_wa = 11'd1024, e_ra = 11'd0;

  task automatic chk(input bit ok, input int req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of strobes and push the expected result.
  task automatic step(input bit w, input bit r);
    bit wfd, rfd, bnd, rc;
    int side;
    exp_t e;
    logic [5:0] cs;
    @(negedge clk);
    wr_stb = w; rd_stb = r;
    wfd = w && (e_wa[4:0] == 5'd31);
    rfd = r && (e_ra[4:0] == 5'd31);
    bnd = wfd || rfd;
    rc  = 1'b0; side = 4;
    e_ra = e_ra + 11'(r);
    e_wa = e_wa + 11'(w);
    if (wfd && !rfd)      e_ofs++;
    else if (rfd && !wfd) e_ofs--;
    if (rfd && e_mcnt > 0) e_mcnt--;
    if (bnd && (e_ofs >= 4 || e_ofs <= -4)) begin
      rc   = 1'b1;
      side = (e_ofs > 0) ? 9 : 10;   // R9 / R10
      e_ofs = 0;
      cs   = e_ra[10:5] + 6'd32;
      e_wa = {cs, 5'd0};
      e_msrc = (e_mcnt > 0) ? 12 : 11; // R12 restart, R11 fresh
      e_mcnt = 128;
    end
    if (bnd) e_div = (e_ofs == 0) ? 588 : (e_ofs > 0) ? 587 : 589;
    e.div = e_div; e.wa = int'(e_wa); e.ra = int'(e_ra);
    e.mu = (e_mcnt > 0) ? 1 : 0;
    e.dreq = !bnd ? 8 : (e_ofs == 0) ? 5 : (e_ofs > 0) ? 7 : 6; // R8 R5 R7 R6
    e.wreq = rc ? side : 4;
    e.mreq = e_msrc;                 // R13 until the first recentre
    q.push_back(e);
  endtask

  // Monitor: compare each expected item mid-cycle after its edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(int'(divisor) == e.div, e.dreq, "divisor", int'(divisor), e.div);
        chk(int'(wr_addr) == e.wa, e.wreq, "wr_addr", int'(wr_addr), e.wa);
        chk(int'(rd_addr) == e.ra, 3, "rd_addr", int'(rd_addr), e.ra); // R3
        chk(int'(mute) == e.mu, e.mreq, "mute", int'(mute), e.mu);
      end
    end
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(divisor == 10'd588, 1, "reset divisor", int'(divisor), 588);
    chk(wr_addr == 11'd1024, 1, "reset wr_addr", int'(wr_addr), 1024);
    chk(rd_addr == 11'd0, 1, "reset rd_addr", int'(rd_addr), 0);
    chk(mute == 1'b1, 1, "reset mute", int'(mute), 1);
    chk(motor_stop == 1'b1, 1, "reset motor_stop", int'(motor_stop), 1);
    rst_n = 1'b1;
    @(posedge clk); #5;
    chk(motor_stop == 1'b0, 2, "motor_stop after release", int'(motor_stop), 0); // R2
    // R7 then R9: writes only
    repeat (4 * 32) step(1'b1, 1'b0);
    // R6 then R10: reads only
    repeat (4 * 32) step(1'b0, 1'b1);
    // R5, R3, R4 wrap, R11/R12 window expiry: paired frames
    repeat (128 * 32) step(1'b1, 1'b1);
    // Fresh recentre, then a second one inside its window (R12)
    repeat (4 * 32) step(1'b1, 1'b0);
    repeat (60 * 32) step(1'b1, 1'b1);
    repeat (4 * 32) step(1'b1, 1'b0);
    repeat (130 * 32) step(1'b1, 1'b1);
    // Unequal rates: writes faster, then reads faster
    for (int i = 0; i < 3000; i++) step(1'b1, (i % 3) != 0);
    for (int i = 0; i < 3000; i++) step((i % 3) != 0, 1'b1);
    // Idle cycles: nothing moves (R8, R3)
    repeat (20) step(1'b0, 1'b0);
    @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule